// File: doc/BRIEF.md
# Oscilloscope Trace Display Sequencer

This block stores the vertical display settings of an oscilloscope and then steps through the displayed traces without further help from the processor. A processor loads one settings word through a plain register write strobe. A serial bus may sit in front of that strobe, but the bus is not part of this block. The settings word picks which of four trace sources are on, how they use the two timebases, whether traces alternate per sweep or are chopped within a sweep, whether the trigger follows the displayed trace, and whether channel B is inverted.

From these settings the block drives one-hot selects for the channel switch, the trigger source selector and the timebase selector. It also drives a channel B invert level, which can double as a trigger slope select, and a one-clock blanking pulse at each chop transition. In alternate display the sequence advances on an end-of-sweep pulse. In chop display it advances on a chop tick. With four sources and an alternating timebase, up to eight traces are visited in turn.

All pins are plain control levels or single-cycle pulses. There is no data stream and no back-pressure: a write is taken in the cycle its strobe is high, and every advance pulse is acted on in the cycle it arrives.

Top module: `scope_trace_sequencer`

## Requirements
- R1: A write (`cfg_wr`=1) loads `cfg_data`. The field layout is: bits 3:0 enable the sources A, B, sum and trigger view (bit 0 = A, bit 1 = B, bit 2 = sum, bit 3 = trigger view); bits 5:4 give the timebase mode; bit 6 selects chop (1) or alternate (0); bit 7 enables composite triggering; bit 8 drives `b_invert`. `b_invert` equals the stored bit 8 from the clock after the write.
- R2: After reset the stored word is all zero. `chan_sel`=0001, `trig_sel`=0001, `tb_sel`=001, and `b_invert` and `chop_blank` are 0.
- R3: Sources are visited in the order A, B, sum, trigger view, then back to A. Disabled sources are skipped. `chan_sel` and `trig_sel` use bit 0 = A, bit 1 = B, bit 2 = sum, bit 3 = trigger view.
- R4: `tb_sel` uses bit 0 = main, bit 1 = main intensified, bit 2 = delayed. Timebase modes 0, 1 and 2 select main, main intensified and delayed, respectively, for every trace.
- R5: In timebase mode 3 (alternate timebase), each source is shown first on main (`tb_sel`=001). On the next advance it is shown on delayed (`tb_sel`=100). Only after that does the sequence move to the next enabled source.
- R6: In alternate display, an advance happens in the clock after a one-cycle `sweep_end` pulse. `chop_tick` has no effect.
- R7: In chop display, an advance happens in the clock after a `chop_tick`. `sweep_end` has no effect. `chop_blank` is 1 for exactly the one clock after each accepted tick, together with the new selection, and is 0 at all other times.
- R8: If no source is enabled, the outputs show `chan_sel`=0001 and `tb_sel`=001, whatever the timebase mode.
- R9: From the clock after a write, the sequence shows the first enabled source of the new word on its first timebase. A write takes priority over an advance pulse in the same cycle.
- R10: With composite triggering on and alternate display, `trig_sel` equals `chan_sel`. Otherwise `trig_sel` selects the first enabled source (A if none).
- R11: `chan_sel`, `trig_sel` and `tb_sel` are each one-hot at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Settings write strobe |
| cfg_data | input | 9 | Settings word, layout in R1 |
| sweep_end | input | 1 | One-cycle end-of-sweep pulse |
| chop_tick | input | 1 | Chop clock tick |
| chan_sel | output | 4 | One-hot channel switch select |
| trig_sel | output | 4 | One-hot trigger source select |
| tb_sel | output | 3 | One-hot timebase select |
| b_invert | output | 1 | Channel B invert / trigger slope |
| chop_blank | output | 1 | Blanking pulse at chop transitions |

## Verification
A wrong source index or timebase phase shows up on `chan_sel` or `tb_sel` in the very next clock. A step lost or taken twice on an advance pulse does the same, because every output is decoded straight from the stored position. Skipped or repeated sources, wrong wrap-around, and a delayed phase entered outside timebase mode 3 all show within one sweep or chop tick. A blanking pulse that is missing or stretched, or a trigger select that fails to track under composite mode, differs from the reference in the same cycle it occurs.

// File: rtl/scope_seq_pkg.sv
package scope_seq_pkg;

  localparam int unsigned N_SRC  = 4;
  localparam int unsigned IDX_W  = $clog2(N_SRC);
  localparam int unsigned N_TB   = 3;
  localparam int unsigned CFG_W  = N_SRC + 5;

  typedef enum logic [1:0] {
    TB_MAIN   = 2'd0,
    TB_INTENS = 2'd1,
    TB_DELAY  = 2'd2,
    TB_ALT    = 2'd3
  } tb_mode_e;

  // Packed MSB first: invert(8) composite(7) chop(6) tb(5:4) enables(3:0)
  typedef struct packed {
    logic             b_inv;
    logic             comp_trig;
    logic             chop;
    tb_mode_e         tb_mode;
    logic [N_SRC-1:0] src_en;
  } cfg_t;

  // Lowest enabled source, zero when none
  function automatic logic [IDX_W-1:0] first_src(input logic [N_SRC-1:0] en);
    logic [IDX_W-1:0] r;
    logic             hit;
    r   = '0;
    hit = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (en[i] && !hit) begin
        r   = IDX_W'(i);
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  // Next enabled source after cur, wrapping; cur itself if it is the only one
  function automatic logic [IDX_W-1:0] next_src(input logic [N_SRC-1:0] en,
                                                input logic [IDX_W-1:0] cur);
    logic [IDX_W-1:0] r;
    logic [IDX_W-1:0] cand;
    logic             hit;
    r   = '0;
    hit = 1'b0;
    for (int k = 1; k <= N_SRC; k++) begin
      cand = cur + IDX_W'(k);
      if (en[cand] && !hit) begin
        r   = cand;
        hit = 1'b1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/scope_cfg_reg.sv
module scope_cfg_reg
  import scope_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output cfg_t             cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q <= cfg_t'(wr_data);
    end
  end

  // R1: stored word matches the last write
  assert_cfg_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_q == cfg_t'($past(wr_data))));

  // R1: settings hold between writes
  assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));

endmodule

// File: rtl/scope_trace_stepper.sv
module scope_trace_stepper
  import scope_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [N_SRC-1:0] wr_src_en,
  input  cfg_t             cfg_q,
  input  logic             sweep_end,
  input  logic             chop_tick,
  output logic [IDX_W-1:0] src_q,
  output logic             phase_q,
  output logic             blank_q
);

  logic advance;
  logic any_src;
  logic split_tb;

  assign advance  = cfg_q.chop ? chop_tick : sweep_end;
  assign any_src  = |cfg_q.src_en;
  assign split_tb = (cfg_q.tb_mode == TB_ALT) && any_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      phase_q <= 1'b0;
      blank_q <= 1'b0;
    end else if (wr_en) begin
      src_q   <= first_src(wr_src_en);
      phase_q <= 1'b0;
      blank_q <= 1'b0;
    end else if (advance) begin
      blank_q <= cfg_q.chop;
      if (split_tb && !phase_q) begin
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
        src_q   <= next_src(cfg_q.src_en, src_q);
      end
    end else begin
      blank_q <= 1'b0;
    end
  end

  // R9: a write restarts at the first enabled source, main phase
  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!phase_q && src_q == first_src($past(wr_src_en))));

  // R6: alternate display ignores chop ticks and waits for end of sweep
  assert_alt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !cfg_q.chop && !sweep_end) |=> ($stable(src_q) && $stable(phase_q)));

  // R7: chop display ignores sweep ends and waits for a tick
  assert_chop_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && cfg_q.chop && !chop_tick) |=> ($stable(src_q) && $stable(phase_q)));

  // R7: blanking only follows a tick taken in chop display
  assert_blank_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blank_q |-> ($past(chop_tick) && $past(cfg_q.chop) && !$past(wr_en)));

  // R5: delayed phase exists only in alternate timebase with a source on
  assert_phase_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q |-> (cfg_q.tb_mode == TB_ALT && any_src));

  // R3: while sources are on, the shown source is one of them
  assert_src_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (any_src && !$past(wr_en)) |-> cfg_q.src_en[src_q]);

endmodule

// File: rtl/scope_select_decode.sv
module scope_select_decode
  import scope_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_t             cfg_q,
  input  logic [IDX_W-1:0] src_q,
  input  logic             phase_q,
  output logic [N_SRC-1:0] chan_sel,
  output logic [N_SRC-1:0] trig_sel,
  output logic [N_TB-1:0]  tb_sel
);

  logic [IDX_W-1:0] trig_idx;
  logic             follow;
  logic [1:0]       tb_idx;

  assign follow   = cfg_q.comp_trig && !cfg_q.chop;
  assign trig_idx = follow ? src_q : first_src(cfg_q.src_en);

  always_comb begin
    if (cfg_q.src_en == '0) begin
      tb_idx = 2'd0;
    end else begin
      unique case (cfg_q.tb_mode)
        TB_MAIN:   tb_idx = 2'd0;
        TB_INTENS: tb_idx = 2'd1;
        TB_DELAY:  tb_idx = 2'd2;
        TB_ALT:    tb_idx = phase_q ? 2'd2 : 2'd0;
        default:   tb_idx = 2'd0;
      endcase
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign chan_sel[g] = (src_q == IDX_W'(g));
    assign trig_sel[g] = (trig_idx == IDX_W'(g));
  end

  for (genvar t = 0; t < N_TB; t++) begin : g_tb
    assign tb_sel[t] = (tb_idx == 2'(t));
  end

  // R11: selectors are one-hot
  assert_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot(chan_sel) && $onehot(trig_sel) && $onehot(tb_sel)));

  // R8: no source enabled means A on main
  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.src_en == '0) |-> (tb_sel == 3'b001));

  // R10: without composite tracking the trigger stays put between writes
  assert_trig_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!follow && $stable(cfg_q)) |-> $stable(trig_sel));

endmodule

// File: rtl/scope_trace_sequencer.sv
module scope_trace_sequencer
  import scope_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [8:0]       cfg_data,
  input  logic             sweep_end,
  input  logic             chop_tick,
  output logic [3:0]       chan_sel,
  output logic [3:0]       trig_sel,
  output logic [2:0]       tb_sel,
  output logic             b_invert,
  output logic             chop_blank
);

  cfg_t             cfg_q;
  cfg_t             wr_cfg;
  logic [IDX_W-1:0] src_q;
  logic             phase_q;

  assign wr_cfg = cfg_t'(cfg_data);

  scope_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_data (cfg_data),
    .cfg_q   (cfg_q)
  );

  scope_trace_stepper u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr),
    .wr_src_en (wr_cfg.src_en),
    .cfg_q     (cfg_q),
    .sweep_end (sweep_end),
    .chop_tick (chop_tick),
    .src_q     (src_q),
    .phase_q   (phase_q),
    .blank_q   (chop_blank)
  );

  scope_select_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_q    (cfg_q),
    .src_q    (src_q),
    .phase_q  (phase_q),
    .chan_sel (chan_sel),
    .trig_sel (trig_sel),
    .tb_sel   (tb_sel)
  );

  assign b_invert = cfg_q.b_inv;

  // R1: invert level follows the written bit from the next clock
  assert_invert_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (b_invert == $past(cfg_data[8])));

  // R10: composite tracking in alternate display
  assert_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.comp_trig && !cfg_q.chop) |-> (trig_sel == chan_sel));

  // R7: blanking is never longer than one clock without a fresh tick
  assert_blank_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chop_blank && !chop_tick) |=> !chop_blank);

endmodule

// File: tb/test_scope_trace_sequencer.sv
module test_scope_trace_sequencer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [8:0] cfg_data = '0;
  logic       sweep_end = 1'b0;
  logic       chop_tick = 1'b0;
  logic [3:0] chan_sel, trig_sel;
  logic [2:0] tb_sel;
  logic       b_invert, chop_blank;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  // reference state
  int m_cfg = 0;
  int m_src = 0;
  int m_ph  = 0;
  int m_blk = 0;

  always #5 clk = ~clk;

  scope_trace_sequencer i_scope_trace_sequencer (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .sweep_end(sweep_end), .chop_tick(chop_tick), .chan_sel(chan_sel),
    .trig_sel(trig_sel), .tb_sel(tb_sel), .b_invert(b_invert),
    .chop_blank(chop_blank)
  );

  function automatic int first_of(int en);
    for (int i = 0; i < 4; i++) if (en[i]) return i;
    return 0;
  endfunction

  function automatic int next_of(int en, int cur);
    for (int k = 1; k <= 4; k++) if (en[(cur + k) % 4]) return (cur + k) % 4;
    return 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    int en, mode, chop, comp, e_tb, e_trig;
    en   = m_cfg & 15;
    mode = (m_cfg >> 4) & 3;
    chop = (m_cfg >> 6) & 1;
    comp = (m_cfg >> 7) & 1;
    if (en == 0) e_tb = 1;            // R8
    else if (mode == 3) e_tb = m_ph ? 4 : 1;
    else e_tb = 1 << mode;
    e_trig = (comp && !chop) ? (1 << m_src) : (1 << first_of(en));
    chk({tag, " R3 chan_sel"}, int'(chan_sel), 1 << m_src);
    chk({tag, " R4/R5 tb_sel"}, int'(tb_sel), e_tb);
    chk({tag, " R10 trig_sel"}, int'(trig_sel), e_trig);
    chk({tag, " R1 b_invert"}, int'(b_invert), (m_cfg >> 8) & 1);
    chk({tag, " R7 chop_blank"}, int'(chop_blank), m_blk);
    chk({tag, " R11 onehot"}, int'($onehot(chan_sel) && $onehot(trig_sel) && $onehot(tb_sel)), 1);
  endtask

  // compare now, then drive inputs and step the model to the next edge
  task automatic cyc(string tag, bit wr, int d, bit se, bit ct);
    int en, chop, adv;
    compare(tag);
    cfg_wr    = wr;
    cfg_data  = 9'(d);
    sweep_end = se;
    chop_tick = ct;
    if (wr) begin                     // R9
      m_cfg = d & 511;
      m_src = first_of(m_cfg & 15);
      m_ph  = 0;
      m_blk = 0;
    end else begin
      en   = m_cfg & 15;
      chop = (m_cfg >> 6) & 1;
      adv  = chop ? ct : se;          // R6 / R7
      m_blk = adv && chop;
      if (adv) begin
        if (((m_cfg >> 4) & 3) == 3 && en != 0 && m_ph == 0) m_ph = 1;  // R5
        else begin
          m_ph  = 0;
          m_src = next_of(en, m_src);
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R2 reset", 2);
    // R3: A, sum, trigger view enabled, alternate display, main
    cyc("R1 write", 1, 9'b0_0_0_00_1101, 0, 0);
    for (int i = 0; i < 8; i++) begin cyc("R3 step", 0, 0, 1, 0); cyc("R3 gap", 0, 0, 0, 0); end
    // R6: chop ticks ignored in alternate display
    for (int i = 0; i < 4; i++) cyc("R6 ignore", 0, 0, 0, 1);
    // R4: each static timebase mode
    for (int m = 0; m < 3; m++) begin
      cyc("R4 write", 1, (m << 4) | 4'b0110, 0, 0);
      for (int i = 0; i < 3; i++) cyc("R4 step", 0, 0, 1, 0);
    end
    // R5 + R10: all sources, alternate timebase, composite, invert
    cyc("R5 write", 1, 9'b1_1_0_11_1111, 0, 0);
    for (int i = 0; i < 10; i++) cyc("R5 step", 0, 0, 1, 0);
    // R7: chop display, sweep ends ignored, blanking on ticks
    cyc("R7 write", 1, 9'b0_1_1_11_1011, 0, 0);
    for (int i = 0; i < 6; i++) begin cyc("R7 tick", 0, 0, 0, 1); cyc("R7 sweep", 0, 0, 1, 0); end
    cyc("R7 tick", 0, 0, 0, 1); cyc("R7 tick", 0, 0, 0, 1);
    // R8: nothing enabled, alternate timebase
    cyc("R8 write", 1, 9'b0_0_0_11_0000, 0, 0);
    for (int i = 0; i < 4; i++) cyc("R8 step", 0, 0, 1, 0);
    // R9: write during an advance wins and restarts
    cyc("R9 setup", 1, 9'b0_0_0_11_1110, 0, 0);
    cyc("R9 adv", 0, 0, 1, 0); cyc("R9 adv", 0, 0, 1, 0);
    cyc("R9 write+adv", 1, 9'b0_0_1_11_1100, 1, 1);
    idle("R9 after", 2);
    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 64);
      cyc("R3 mix", r == 0, int'($urandom % 512), ($urandom % 4) == 0, ($urandom % 3) == 0);
    end
    compare("R3 final");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule